// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a CPU and a plug-in cartridge. It turns each CPU address inside the 32 KB cartridge region into a physical ROM address, or into a physical RAM address when cartridge RAM is switched in. The mapping depends on the ROM size, a static code that comes from the cartridge. It also depends on an 8-bit control register that the CPU writes; the block keeps its own copy of that register. Control bits 5 and 6 choose a 32 KB ROM page on large cartridges, or switch cartridge RAM into the top of the region.

The cartridge region is split into five windows:
- Window 0 covers 0x0000-0x1FFF.
- Window 1 covers 0x2000-0x3FFF.
- Window 2 covers 0x4000-0x5FFF.
- Window 3 covers 0x6000-0x6FFF.
- Window 4 covers 0x7000-0x7FFF.

Each window starts at a base in ROM, and that base depends on the ROM size. The outputs are combinational from the CPU address and the registered control byte. The ROM and RAM arrays sit outside the block and use the addresses it produces.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the control register holds 0x00. This selects ROM page 0 and leaves RAM disabled, so with a 128 KB ROM the address 0x7ABC maps to ROM 0x07ABC with no RAM select.
- R2: The ROM size code is 0 (no ROM), 1 (8 KB), 2 (16 KB), 3 (32 KB), 4 (64 KB) or 5 (128 KB). For codes 0 and 1, and for unused codes 6 and 7, windows 0 to 3 start at ROM 0x0000 and window 4 starts at 0x1000.
- R3: With code 2 the window bases are 0x0000, 0x2000, 0x0000, 0x2000 and 0x3000.
- R4: With code 3 the window bases are 0x0000, 0x2000, 0x4000, 0x6000 and 0x7000, so the ROM address equals the CPU address.
- R5: With code 4 the code 3 layout is used, and 0x8000 is added when control bit 5 is 1.
- R6: With code 5 the code 3 layout is used, plus control bits [6:5] multiplied by 0x8000.
- R7: With code 5 and RAM present, control bit 6 at 1 switches RAM in for window 4 only. Control bit 5 does not enable RAM in this case.
- R8: With codes 0 to 4 and RAM present, control bit 5 at 1 enables RAM. A 4 KB RAM (RAM code 1) replaces window 4 at RAM offset 0x000 plus the offset within the window.
- R9: An 8 KB RAM (RAM code 2) replaces window 3 at RAM offset 0x0000 and window 4 at RAM offset 0x1000. Windows 0 to 2 never select RAM.
- R10: RAM select is high only for a read or a write to a window mapped to enabled RAM. RAM write enable is high only for a write to such a window. A write to a window mapped to ROM raises neither output.
- R11: A control write is registered on the clock edge. An access in the cycle right after that edge uses the new mapping.
- R12: With RAM code 0 or 3 (no RAM), RAM select never rises, whatever the control bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_size | input | 3 | Static ROM size code |
| ram_size | input | 2 | Static RAM size code |
| cpu_addr | input | 15 | Offset in the cartridge region |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register write data |
| rom_addr | output | 17 | Physical ROM address |
| ram_addr | output | 13 | Physical RAM address |
| ram_sel | output | 1 | Access goes to RAM |
| ram_we | output | 1 | RAM write enable |

## Verification
A control write has no visible effect until the next rising edge latches it. The bench therefore drives the write before an edge and probes the mapping one nanosecond after that edge, which is the first cycle the new byte can be seen. Address and strobe changes reach `rom_addr`, `ram_addr`, `ram_sel` and `ram_we` in the same cycle, with no register in the path. Each probe changes the inputs and samples one nanosecond later, well before the next edge. Randomised size codes, control bytes and addresses are mixed with directed window-boundary probes, and each probe is compared against a bench model that uses masks and adds rather than window tables.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned CPU_AW = 15;
  localparam int unsigned ROM_AW = 17;
  localparam int unsigned RAM_AW = 13;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned NWIN   = 5;
  localparam int unsigned LOC_W  = 13;
  localparam int unsigned PAGE_LO = 5;
  localparam int unsigned RAM_BIG_BIT = 6;

  typedef enum logic [2:0] {
    ROM_NONE = 3'd0, ROM_8K = 3'd1, ROM_16K = 3'd2,
    ROM_32K  = 3'd3, ROM_64K = 3'd4, ROM_128K = 3'd5
  } rom_size_e;

  typedef enum logic [1:0] {
    RAM_NONE = 2'd0, RAM_4K = 2'd1, RAM_8K = 2'd2
  } ram_size_e;

  typedef logic [2:0] win_t;

  function automatic win_t win_index(input logic [CPU_AW-1:0] a);
    if (a[14:13] != 2'b11) return win_t'(a[14:13]);
    return a[12] ? win_t'(4) : win_t'(3);
  endfunction

  function automatic logic [LOC_W-1:0] win_local(input logic [CPU_AW-1:0] a, input win_t w);
    if (w >= win_t'(3)) return {1'b0, a[11:0]};
    return a[12:0];
  endfunction

  function automatic logic [CPU_AW-1:0] layout_base(input logic [2:0] sz, input win_t w);
    logic [CPU_AW-1:0] b;
    case (sz)
      ROM_16K: case (w)
        3'd1, 3'd3: b = 15'h2000;
        3'd4:       b = 15'h3000;
        default:    b = 15'h0000;
      endcase
      ROM_32K, ROM_64K, ROM_128K: case (w)
        3'd1:    b = 15'h2000;
        3'd2:    b = 15'h4000;
        3'd3:    b = 15'h6000;
        3'd4:    b = 15'h7000;
        default: b = 15'h0000;
      endcase
      default: b = (w == win_t'(4)) ? 15'h1000 : 15'h0000;
    endcase
    return b;
  endfunction

  function automatic logic [ROM_AW-1:0] page_base(input logic [2:0] sz, input logic [CTL_W-1:0] c);
    case (sz)
      ROM_64K:  return {1'b0, c[PAGE_LO], 15'h0000};
      ROM_128K: return {c[PAGE_LO+1:PAGE_LO], 15'h0000};
      default:  return '0;
    endcase
  endfunction

  function automatic logic ram_present(input logic [1:0] rs);
    return (rs == RAM_4K) || (rs == RAM_8K);
  endfunction

  function automatic logic ram_enabled(input logic [2:0] sz, input logic [1:0] rs,
                                       input logic [CTL_W-1:0] c);
    if (!ram_present(rs)) return 1'b0;
    if (sz == ROM_128K) return c[RAM_BIG_BIT];
    return c[PAGE_LO];
  endfunction

  function automatic logic ram_window(input logic [2:0] sz, input logic [1:0] rs, input win_t w);
    if (w == win_t'(4)) return 1'b1;
    return (w == win_t'(3)) && (sz != ROM_128K) && (rs == RAM_8K);
  endfunction

  function automatic logic [RAM_AW-1:0] ram_offset(input logic [1:0] rs, input win_t w,
                                                   input logic [LOC_W-1:0] loc);
    logic [RAM_AW-1:0] hi;
    hi = (w == win_t'(4) && rs == RAM_8K) ? 13'h1000 : 13'h0000;
    return hi + {1'b0, loc[11:0]};
  endfunction
endpackage

// File: rtl/cbm_ctl_reg.sv
module cbm_ctl_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/cbm_win_dec.sv
module cbm_win_dec
  import cbm_pkg::*;
#(
  parameter int unsigned AW = CPU_AW,
  parameter int unsigned NW = NWIN
) (
  input  logic [AW-1:0]    addr,
  output win_t             win,
  output logic [LOC_W-1:0] loc,
  output logic [NW-1:0]    hit
);
  always_comb begin
    win = win_index(addr);
    loc = win_local(addr, win);
  end

  for (genvar i = 0; i < NW; i++) begin : g_hit
    assign hit[i] = (win == win_t'(i));
  end
endmodule

// File: rtl/cbm_rom_map.sv
module cbm_rom_map
  import cbm_pkg::*;
#(
  parameter int unsigned AW = ROM_AW
) (
  input  logic [2:0]       rom_size,
  input  logic [CTL_W-1:0] ctl,
  input  win_t             win,
  input  logic [LOC_W-1:0] loc,
  output logic [AW-1:0]    rom_addr
);
  localparam int unsigned PAD_B = AW - CPU_AW;
  localparam int unsigned PAD_L = AW - LOC_W;

  always_comb begin
    rom_addr = page_base(rom_size, ctl)
             + {{PAD_B{1'b0}}, layout_base(rom_size, win)}
             + {{PAD_L{1'b0}}, loc};
  end
endmodule

// File: rtl/cbm_ram_gate.sv
module cbm_ram_gate
  import cbm_pkg::*;
#(
  parameter int unsigned AW = RAM_AW
) (
  input  logic [2:0]       rom_size,
  input  logic [1:0]       ram_size,
  input  logic [CTL_W-1:0] ctl,
  input  win_t             win,
  input  logic [LOC_W-1:0] loc,
  input  logic             rd,
  input  logic             wr,
  output logic             ram_en,
  output logic             ram_hit,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_sel,
  output logic             ram_we
);
  always_comb begin
    ram_en   = ram_enabled(rom_size, ram_size, ctl);
    ram_hit  = ram_en && ram_window(rom_size, ram_size, win);
    ram_addr = ram_offset(ram_size, win, loc);
    ram_sel  = ram_hit && (rd || wr);
    ram_we   = ram_hit && wr;
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int unsigned CAW = CPU_AW,
  parameter int unsigned RMW = ROM_AW,
  parameter int unsigned RAW = RAM_AW,
  parameter int unsigned CW  = CTL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     rom_size,
  input  logic [1:0]     ram_size,
  input  logic [CAW-1:0] cpu_addr,
  input  logic           cpu_rd,
  input  logic           cpu_wr,
  input  logic           ctl_wr,
  input  logic [CW-1:0]  ctl_data,
  output logic [RMW-1:0] rom_addr,
  output logic [RAW-1:0] ram_addr,
  output logic           ram_sel,
  output logic           ram_we
);
  logic [CW-1:0]    ctl_q;
  win_t             win;
  logic [LOC_W-1:0] loc;
  logic [NWIN-1:0]  win_hit;
  logic             ram_en;
  logic             ram_hit;

  cbm_ctl_reg #(.W(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .d(ctl_data), .q(ctl_q)
  );

  cbm_win_dec #(.AW(CAW), .NW(NWIN)) u_dec (
    .addr(cpu_addr), .win(win), .loc(loc), .hit(win_hit)
  );

  cbm_rom_map #(.AW(RMW)) u_rom (
    .rom_size(rom_size), .ctl(ctl_q), .win(win), .loc(loc), .rom_addr(rom_addr)
  );

  cbm_ram_gate #(.AW(RAW)) u_ram (
    .rom_size(rom_size), .ram_size(ram_size), .ctl(ctl_q), .win(win), .loc(loc),
    .rd(cpu_rd), .wr(cpu_wr), .ram_en(ram_en), .ram_hit(ram_hit),
    .ram_addr(ram_addr), .ram_sel(ram_sel), .ram_we(ram_we)
  );
endmodule

// File: rtl/cbm_chk.sv
module cbm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  rom_size,
  input logic [1:0]  ram_size,
  input logic [14:0] cpu_addr,
  input logic        cpu_wr,
  input logic        ctl_wr,
  input logic [7:0]  ctl_data,
  input logic [7:0]  ctl_q,
  input logic [4:0]  win_hit,
  input logic        ram_sel,
  input logic        ram_we
);
  // R11
  ctl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q == $past(ctl_data)));

  // R10
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && ram_sel));

  // R12
  no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_size == 2'd0 || ram_size == 2'd3) |-> !ram_sel);

  // R8
  small_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_size != 3'd5 && !ctl_q[5]) |-> !ram_sel);

  // R7
  big_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_size == 3'd5 && !ctl_q[6]) |-> !ram_sel);

  // R9
  low_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] != 2'b11) |-> !ram_sel);

  // R2
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_hit) == 1);
endmodule

bind cart_bank_mapper cbm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rom_size(rom_size), .ram_size(ram_size),
  .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .ctl_q(ctl_q), .win_hit(win_hit), .ram_sel(ram_sel), .ram_we(ram_we)
);

// File: tb/cart_bank_mapper_bench.sv
`timescale 1ns/1ps
module cart_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rom_size = '0;
  logic [1:0]  ram_size = '0;
  logic [14:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_data = '0;
  logic [16:0] rom_addr;
  logic [12:0] ram_addr;
  logic        ram_sel;
  logic        ram_we;

  int checks = 0;
  int errors = 0;
  logic [7:0] ctl_m = '0;
  bit done = 0;

  always #5 clk = ~clk;

  cart_bank_mapper u_cart_bank_mapper (
    .clk(clk), .rst_n(rst_n), .rom_size(rom_size), .ram_size(ram_size),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ctl_wr(ctl_wr),
    .ctl_data(ctl_data), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .ram_sel(ram_sel), .ram_we(ram_we)
  );

  function automatic logic [16:0] m_rom(logic [2:0] s, logic [7:0] c, logic [14:0] a);
    case (s)
      3'd2:    return {2'b0, a & 15'h3FFF};
      3'd3:    return {2'b0, a};
      3'd4:    return {2'b0, a} + (c[5] ? 17'h08000 : 17'h0);
      3'd5:    return {2'b0, a} + 17'(c[6:5]) * 17'h08000;
      default: return {2'b0, a & 15'h1FFF};
    endcase
  endfunction

  function automatic logic m_hit(logic [2:0] s, logic [1:0] r, logic [7:0] c, logic [14:0] a);
    if (!(r == 2'd1 || r == 2'd2)) return 1'b0;
    if (s == 3'd5) return c[6] && (a >= 15'h7000);
    if (!c[5]) return 1'b0;
    return (r == 2'd2) ? (a >= 15'h6000) : (a >= 15'h7000);
  endfunction

  function automatic logic [12:0] m_ram(logic [1:0] r, logic [14:0] a);
    return (r == 2'd2) ? 13'(a & 15'h1FFF) : 13'(a & 15'h0FFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = d;
    @(posedge clk);
    #1 ctl_wr = 1'b0;
    ctl_m = d;
  endtask

  task automatic probe(string req, logic [14:0] a, logic rd, logic wr);
    logic h;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #1;
    h = m_hit(rom_size, ram_size, ctl_m, a);
    chk(req, 32'(rom_addr), 32'(m_rom(rom_size, ctl_m, a)));
    chk(req, 32'(ram_sel), 32'(h && (rd || wr)));
    chk(req, 32'(ram_we), 32'(h && wr));
    if (h) chk(req, 32'(ram_addr), 32'(m_ram(ram_size, a)));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state: page 0, RAM off
    rom_size = 3'd5; ram_size = 2'd2;
    cpu_addr = 15'h7ABC; cpu_rd = 1'b1; #1;
    chk("R1", 32'(rom_addr), 32'h07ABC);
    chk("R1", 32'(ram_sel), 32'h0);
    // R2 8 KB and no-ROM layouts
    rom_size = 3'd1; ram_size = 2'd0;
    probe("R2", 15'h0123, 1, 0); probe("R2", 15'h6FFF, 1, 0); probe("R2", 15'h7004, 1, 0);
    rom_size = 3'd0; probe("R2", 15'h4010, 1, 0);
    // R3
    rom_size = 3'd2;
    probe("R3", 15'h4001, 1, 0); probe("R3", 15'h6002, 1, 0); probe("R3", 15'h7FFF, 1, 0);
    // R4
    rom_size = 3'd3; probe("R4", 15'h5555, 1, 0);
    // R5
    rom_size = 4'd4; wr_ctl(8'h20); probe("R5", 15'h2345, 1, 0);
    // R6 page 3
    rom_size = 3'd5; wr_ctl(8'h60); probe("R6", 15'h7001, 1, 0);
    // R7 bit6 with RAM: only window 4
    ram_size = 2'd2; wr_ctl(8'h40);
    probe("R7", 15'h7010, 1, 0); probe("R7", 15'h6010, 0, 1);
    wr_ctl(8'h20); probe("R7", 15'h7010, 1, 1);
    // R8 4 KB RAM in window 4
    rom_size = 3'd3; ram_size = 2'd1; wr_ctl(8'h20);
    probe("R8", 15'h7ABC, 1, 0); probe("R8", 15'h6ABC, 1, 0);
    // R9 8 KB RAM in windows 3 and 4
    ram_size = 2'd2;
    probe("R9", 15'h6000, 1, 0); probe("R9", 15'h7FFF, 1, 0); probe("R9", 15'h5FFF, 1, 0);
    // R10 writes
    probe("R10", 15'h6100, 0, 1); probe("R10", 15'h1000, 0, 1); probe("R10", 15'h7100, 0, 0);
    // R11 mapping visible in the cycle after the write
    rom_size = 3'd4; cpu_addr = 15'h0100; cpu_rd = 1'b1;
    @(negedge clk); ctl_wr = 1'b1; ctl_data = 8'h20;
    @(posedge clk); #1 ctl_wr = 1'b0; ctl_m = 8'h20;
    chk("R11", 32'(rom_addr), 32'h08100);
    // R12 no RAM
    ram_size = 2'd0; wr_ctl(8'h60); probe("R12", 15'h7000, 1, 1);
    ram_size = 2'd3; probe("R12", 15'h6800, 0, 1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      rom_size = 3'($urandom_range(0, 5));
      ram_size = 2'($urandom_range(0, 3));
      if (($urandom & 3) == 0) wr_ctl(8'($urandom));
      probe("R2", 15'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    summary();
    $finish;
  end
endmodule